// File: doc/BRIEF.md
# Interrupt Source Masking and Routing Bank

This block collects a set of level-sensitive interrupt sources (32 by default) and decides, for each one, whether it goes to the normal interrupt path or to the fast interrupt path. Each source's request is the OR of its hardware input line and a software-raised request bit. Software can raise and drop these requests through the register port, which makes it possible to trigger any source without touching the hardware line.

Sources routed to the normal path are gated by an enable mask. The resulting masked vector is passed on, unchanged, to a downstream priority resolver. Sources routed to the fast path are not gated by the enable mask. Any active fast-path source drives the single fast request output directly. Both the enable mask and the software request register are changed through separate set and clear offsets, so that one agent cannot undo another agent's bits by accident. The fast-path route mask is an ordinary read/write register. A protection bit is stored and read back, but it has no effect on the block's behaviour.

The register port is a single-cycle interface. Read data comes back combinationally in the same cycle as the request. A write takes effect on the rising clock edge. The top 32 bytes of the 4 KiB window return a fixed eight-byte identification sequence.

Top module: `irq_route_bank`

## Requirements
- R1: Word offset 2 (byte 0x008) reads the raw request vector: for each source, its hardware line OR its software request bit.
- R2: Word offset 0 (byte 0x000) reads, and port `irq_vec` drives, raw AND enable AND NOT route. These two values always agree.
- R3: Word offset 1 (byte 0x004) reads raw AND route. The enable mask has no effect on this value.
- R4: `fast_req` is high exactly when at least one bit of raw AND route is set.
- R5: A write to word offset 4 (byte 0x010) sets the enable bits at the positions of the ones in the write data. A write to word offset 5 (byte 0x014) clears them. Reading offset 4 returns the enable mask. Reading offset 5 returns zero.
- R6: A write to word offset 6 (byte 0x018) sets software request bits at the positions of the ones in the write data. A write to word offset 7 (byte 0x01C) clears them. Reading offset 6 returns the software request register. Reading offset 7 returns zero.
- R7: Word offset 3 (byte 0x00C) is the route mask. It is fully readable and writable. A 1 in a bit position sends that source to the fast path.
- R8: Word offset 8 (byte 0x020) stores bit 0 of the write data as the protection flag. A read returns that flag in bit 0, with all other bits zero.
- R9: Writes to word offsets 0, 1 and 2 change no register.
- R10: Byte offsets 0xFE0 to 0xFFF hold one identification byte per word, in the low 8 bits, upper bits zero. In word order from 0xFE0 the bytes are 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: A read of any other offset returns zero. A write to any other offset changes no register.
- R12: A synchronous, active-high reset clears the enable, route, software request and protection registers.
- R13: Read data reflects the state of the current cycle. A write is visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NUM_SRC | Hardware interrupt source levels |
| bus_sel | input | 1 | Register port access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; zero when no read is presented |
| fast_req | output | 1 | Fast interrupt request |
| irq_vec | output | NUM_SRC | Masked normal-path status to the priority resolver |

## Verification
The bench builds the block with the default NUM_SRC of 32. This fills every register to the full bus width, so the upper bits of every set/clear offset and of the route mask are exercised. A behavioural model keeps its own enable, route, software and protection values and checks `irq_vec` and `fast_req` on every clock. Random sequences of line changes and register accesses reach conflicting cases, such as a source that is enabled and also routed to the fast path, or a software request raised on a line that is already high.

// File: rtl/irb_pkg.sv
`timescale 1ns/1ps
package irb_pkg;

    localparam int BUS_AW   = 12;
    localparam int BUS_DW   = 32;
    localparam int ID_COUNT = 8;
    localparam int ID_IW    = $clog2(ID_COUNT);
    localparam logic [BUS_AW-1:0] ID_BASE = 12'hFE0;

    // Word offsets; software decodes these, so the values are fixed.
    typedef enum logic [3:0] {
        OFS_NSTAT = 4'd0,
        OFS_FSTAT = 4'd1,
        OFS_RAW   = 4'd2,
        OFS_ROUTE = 4'd3,
        OFS_ENSET = 4'd4,
        OFS_ENCLR = 4'd5,
        OFS_SWSET = 4'd6,
        OFS_SWCLR = 4'd7,
        OFS_LOCK  = 4'd8,
        OFS_NONE  = 4'd15
    } reg_sel_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_ofs(input logic [BUS_AW-1:0] a);
        logic [BUS_AW-3:0] word;
        word = a[BUS_AW-1:2];
        if (word <= (BUS_AW-2)'(8))
            return reg_sel_e'(word[3:0]);
        return OFS_NONE;
    endfunction

    function automatic logic is_id_addr(input logic [BUS_AW-1:0] a);
        return a >= ID_BASE;
    endfunction

    function automatic logic [7:0] id_byte(input logic [ID_IW-1:0] i);
        case (i)
            3'd0:    return 8'h90;
            3'd1:    return 8'h11;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/irb_ctl_regs.sv
`timescale 1ns/1ps
module irb_ctl_regs
    import irb_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  reg_sel_e            wsel,
    input  logic [BUS_DW-1:0]   wdata,
    output logic [NUM_SRC-1:0]  en_q,
    output logic [NUM_SRC-1:0]  route_q,
    output logic [NUM_SRC-1:0]  sw_q,
    output logic                prot_q
);
    logic [NUM_SRC-1:0] wmask;
    assign wmask = wdata[NUM_SRC-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            route_q <= '0;
            sw_q    <= '0;
            prot_q  <= 1'b0;
        end else if (wr_stb) begin
            case (wsel)
                OFS_ROUTE: route_q <= wmask;
                OFS_ENSET: en_q    <= en_q | wmask;
                OFS_ENCLR: en_q    <= en_q & ~wmask;
                OFS_SWSET: sw_q    <= sw_q | wmask;
                OFS_SWCLR: sw_q    <= sw_q & ~wmask;
                OFS_LOCK:  prot_q  <= wdata[0];
                default:   ;
            endcase
        end
    end

    // R5: set leaves all written ones high, clear drops them
    p_enset_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wsel == OFS_ENSET) |=> ((en_q & $past(wmask)) == $past(wmask)));
    p_enclr_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wsel == OFS_ENCLR) |=> ((en_q & $past(wmask)) == '0));
    // R6
    p_swclr_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wsel == OFS_SWCLR) |=> ((sw_q & $past(wmask)) == '0));
    // R9 / R11: status and unmapped writes leave every register alone
    p_status_wr_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && (wsel == OFS_NSTAT || wsel == OFS_FSTAT || wsel == OFS_RAW || wsel == OFS_NONE))
        |=> ($stable(en_q) && $stable(route_q) && $stable(sw_q) && $stable(prot_q)));

endmodule

// File: rtl/irb_route.sv
`timescale 1ns/1ps
module irb_route #(
    parameter int NUM_SRC = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  hw_lvl,
    input  logic [NUM_SRC-1:0]  sw_q,
    input  logic [NUM_SRC-1:0]  en_q,
    input  logic [NUM_SRC-1:0]  route_q,
    output logic [NUM_SRC-1:0]  raw,
    output logic [NUM_SRC-1:0]  nstat,
    output logic [NUM_SRC-1:0]  fstat,
    output logic                fast_req
);
    // One steering cell per source.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic act;
        assign act      = hw_lvl[i] | sw_q[i];
        assign raw[i]   = act;
        assign nstat[i] = act & en_q[i] & ~route_q[i];
        assign fstat[i] = act & route_q[i];
    end

    assign fast_req = |fstat;

    // R3: a routed hardware line reaches fast_req regardless of enable
    p_ungated_r3: assert property (@(posedge clk) disable iff (rst)
        (|(hw_lvl & route_q)) |-> fast_req);
    // R2: normal path never carries a disabled or routed source
    p_irq_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
        ((nstat & ~en_q) == '0) && ((nstat & route_q) == '0));
    // R1: any hardware line shows in raw
    p_raw_cover_r1: assert property (@(posedge clk) disable iff (rst)
        ((raw & hw_lvl) == hw_lvl));

endmodule

// File: rtl/irb_readmux.sv
`timescale 1ns/1ps
module irb_readmux
    import irb_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_stb,
    input  reg_sel_e            rsel,
    input  logic                id_hit,
    input  logic [ID_IW-1:0]    id_idx,
    input  logic [NUM_SRC-1:0]  raw,
    input  logic [NUM_SRC-1:0]  nstat,
    input  logic [NUM_SRC-1:0]  fstat,
    input  logic [NUM_SRC-1:0]  en_q,
    input  logic [NUM_SRC-1:0]  route_q,
    input  logic [NUM_SRC-1:0]  sw_q,
    input  logic                prot_q,
    output logic [BUS_DW-1:0]   rdata
);
    function automatic logic [BUS_DW-1:0] widen(input logic [NUM_SRC-1:0] v);
        logic [BUS_DW-1:0] t;
        t = '0;
        t[NUM_SRC-1:0] = v;
        return t;
    endfunction

    always_comb begin
        rdata = '0;
        if (rd_stb) begin
            if (id_hit) begin
                rdata[7:0] = id_byte(id_idx);
            end else begin
                case (rsel)
                    OFS_NSTAT: rdata = widen(nstat);
                    OFS_FSTAT: rdata = widen(fstat);
                    OFS_RAW:   rdata = widen(raw);
                    OFS_ROUTE: rdata = widen(route_q);
                    OFS_ENSET: rdata = widen(en_q);
                    OFS_SWSET: rdata = widen(sw_q);
                    OFS_LOCK:  rdata[0] = prot_q;
                    default:   rdata = '0;
                endcase
            end
        end
    end

    // R10: identification words never carry bits above the byte
    p_id_byte_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && id_hit) |-> (rdata[BUS_DW-1:8] == '0));
    // R8: protection readback is a single bit
    p_lock_bit_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !id_hit && rsel == OFS_LOCK) |-> (rdata[BUS_DW-1:1] == '0));

endmodule

// File: rtl/irq_route_bank.sv
`timescale 1ns/1ps
module irq_route_bank
    import irb_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_lvl,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [11:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                fast_req,
    output logic [NUM_SRC-1:0]  irq_vec
);
    bus_req_t           req;
    reg_sel_e           sel_ofs;
    logic               id_hit;
    logic               wr_stb;
    logic               rd_stb;
    logic [NUM_SRC-1:0] en_q, route_q, sw_q;
    logic               prot_q;
    logic [NUM_SRC-1:0] raw, nstat, fstat;

    assign req     = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};
    assign id_hit  = is_id_addr(req.addr);
    assign sel_ofs = decode_ofs(req.addr);
    assign wr_stb  = req.sel & req.wr;
    assign rd_stb  = req.sel & ~req.wr;

    irb_ctl_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wsel    (sel_ofs),
        .wdata   (req.wdata),
        .en_q    (en_q),
        .route_q (route_q),
        .sw_q    (sw_q),
        .prot_q  (prot_q)
    );

    irb_route #(.NUM_SRC(NUM_SRC)) u_route (
        .clk      (clk),
        .rst      (rst),
        .hw_lvl   (src_lvl),
        .sw_q     (sw_q),
        .en_q     (en_q),
        .route_q  (route_q),
        .raw      (raw),
        .nstat    (nstat),
        .fstat    (fstat),
        .fast_req (fast_req)
    );

    irb_readmux #(.NUM_SRC(NUM_SRC)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_stb  (rd_stb),
        .rsel    (sel_ofs),
        .id_hit  (id_hit),
        .id_idx  (req.addr[ID_IW+1:2]),
        .raw     (raw),
        .nstat   (nstat),
        .fstat   (fstat),
        .en_q    (en_q),
        .route_q (route_q),
        .sw_q    (sw_q),
        .prot_q  (prot_q),
        .rdata   (bus_rdata)
    );

    assign irq_vec = nstat;

    // R12: one cycle after reset every control register is clear, so nothing is enabled
    p_reset_clear_r12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_vec == '0));

endmodule

// File: tb/test_irq_route_bank.sv
`timescale 1ns/1ps
module test_irq_route_bank;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] src_lvl = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fast_req;
    logic [N-1:0] irq_vec;

    int n_chk = 0;
    int n_err = 0;
    bit running = 0;
    bit done = 0;

    // behavioural model state
    logic [31:0] m_en = 0, m_rt = 0, m_sw = 0;
    logic        m_prot = 0;
    byte unsigned idb [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    always #2 clk = ~clk;

    irq_route_bank #(.NUM_SRC(N)) i_irq_route_bank (
        .clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fast_req(fast_req), .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] raw_m();
        return src_lvl | m_sw;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        int w;
        if (a >= 12'hFE0) return {24'h0, idb[a[4:2]]};
        w = int'(a >> 2);
        case (w)
            0: return raw_m() & m_en & ~m_rt;
            1: return raw_m() & m_rt;
            2: return raw_m();
            3: return m_rt;
            4: return m_en;
            6: return m_sw;
            8: return {31'h0, m_prot};
            default: return 32'h0;
        endcase
    endfunction

    // every-cycle comparison of the interrupt outputs
    always @(posedge clk) begin
        #1;
        if (running && !rst) begin
            chk("R2 irq_vec", irq_vec, raw_m() & m_en & ~m_rt);
            chk("R4 fast_req", {31'h0, fast_req}, {31'h0, |(raw_m() & m_rt)});
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        int w;
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        w = int'(a >> 2);
        if (a < 12'hFE0) begin
            case (w)
                3: m_rt = d;
                4: m_en = m_en | d;
                5: m_en = m_en & ~d;
                6: m_sw = m_sw | d;
                7: m_sw = m_sw & ~d;
                8: m_prot = d[0];
                default: ;
            endcase
        end
        #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input string tag, input logic [11:0] a);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp_rd(a));
        bus_sel = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // dirty the registers before a second reset
        repeat (3) @(posedge clk);
        #1 rst = 0;
        bus_write(12'h010, 32'hFFFF_FFFF);
        bus_write(12'h00C, 32'h1234_5678);
        bus_write(12'h018, 32'h0000_00F0);
        bus_write(12'h020, 32'h1);
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
        m_en = 0; m_rt = 0; m_sw = 0; m_prot = 0;
        bus_read("R12 route after reset", 12'h00C);
        bus_read("R12 enable after reset", 12'h010);
        bus_read("R12 swreq after reset", 12'h018);
        bus_read("R12 prot after reset", 12'h020);
        running = 1;

        // R1 raw merge
        @(negedge clk) src_lvl = 32'hA000_0005;
        bus_write(12'h018, 32'h0000_0300);
        bus_read("R1 raw", 12'h008);
        bus_read("R2 nstat all disabled", 12'h000);

        // R5 enable set/clear
        bus_write(12'h010, 32'h0000_00FF);
        bus_write(12'h010, 32'h8000_0F00);
        bus_read("R5 enable after two sets", 12'h010);
        bus_write(12'h014, 32'h0000_00F0);
        bus_read("R5 enable after clear", 12'h010);
        bus_read("R5 clear offset reads zero", 12'h014);
        bus_read("R2 nstat", 12'h000);

        // R7 / R3 route ungated by enable
        bus_write(12'h010, 32'h0);
        bus_write(12'h014, 32'hFFFF_FFFF);
        bus_write(12'h00C, 32'h2000_0004);
        bus_read("R7 route readback", 12'h00C);
        bus_read("R3 fstat with enable off", 12'h004);
        @(negedge clk); #0;
        chk("R3 fast_req ungated", {31'h0, fast_req}, 32'h1);

        // R6 sw set/clear, and R4 fast_req drop
        bus_write(12'h01C, 32'hFFFF_FFFF);
        @(negedge clk) src_lvl = 32'h0;
        bus_write(12'h018, 32'h0000_0004);
        bus_read("R6 swreq set", 12'h018);
        bus_read("R6 clear offset reads zero", 12'h01C);
        @(negedge clk); #0;
        chk("R4 fast_req from sw", {31'h0, fast_req}, 32'h1);
        bus_write(12'h01C, 32'h0000_0004);
        @(negedge clk); #0;
        chk("R4 fast_req dropped", {31'h0, fast_req}, 32'h0);

        // R8 protection
        bus_write(12'h020, 32'hFFFF_FFFE);
        bus_read("R8 prot bit0 zero", 12'h020);
        bus_write(12'h020, 32'hFFFF_FFFF);
        bus_read("R8 prot only bit0", 12'h020);

        // R9 status writes ignored
        bus_write(12'h000, 32'hFFFF_FFFF);
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_write(12'h008, 32'hFFFF_FFFF);
        bus_read("R9 route unchanged", 12'h00C);
        bus_read("R9 enable unchanged", 12'h010);
        bus_read("R9 swreq unchanged", 12'h018);

        // R10 identification
        for (int k = 0; k < 8; k++)
            bus_read("R10 id byte", 12'hFE0 + 12'(k * 4));
        bus_read("R10 id byte with low address bits", 12'hFE7);

        // R11 unmapped
        bus_read("R11 unmapped 0x024", 12'h024);
        bus_read("R11 unmapped 0x800", 12'h800);
        bus_write(12'h030, 32'hFFFF_FFFF);
        bus_write(12'h7FC, 32'hFFFF_FFFF);
        bus_write(12'hFE0, 32'hFFFF_FFFF);
        bus_read("R11 enable unchanged", 12'h010);
        bus_read("R11 route unchanged", 12'h00C);

        // R13 write timing
        @(negedge clk) src_lvl = 32'h0000_0010;
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 12'h010; bus_wdata = 32'h10;
        #1 chk("R13 write not visible before edge", irq_vec, 32'h0);
        @(posedge clk); m_en = m_en | 32'h10;
        #1 bus_sel = 0; bus_wr = 0;
        chk("R13 write visible after edge", irq_vec, 32'h10);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [11:0] a;
            op = $urandom_range(0, 3);
            a = 12'($urandom_range(0, 9) * 4);
            if ($urandom_range(0, 7) == 0) a = 12'hFE0 + 12'($urandom_range(0, 7) * 4);
            case (op)
                0: begin @(negedge clk) src_lvl = $urandom; end
                1: bus_write(a, $urandom);
                default: bus_read("R1 R2 R3 random read", a);
            endcase
        end

        repeat (2) @(negedge clk);
        running = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule